// File: doc/BRIEF.md
# Frame-Buffered External Bus Master

This block carries frames of 32-bit words between a 256-word buffer that the CPU reads and writes and a simple external parallel bus made of address, data, strobe, read/write and a wait input. The CPU sets a bus start address, a frame length, a transfer direction, and a control word. The control word covers address stepping, address restore, automatic re-arming, a last-word marker, and how bus cycles are stretched. Every frame runs from buffer word 0 up to word TRIGGER, so it is TRIGGER+1 words long.

A frame is handed over through the buffer itself. The CPU accesses the buffer word whose index equals TRIGGER. In send mode, writing that word starts an outbound frame. In fetch mode, writing the operation register starts the first inbound frame. After that, a CPU read of the last word re-arms the fetch, but only when auto-restart is enabled.

The bus side runs on a clock enable at half the system rate, which appears on `busPhase`. Each bus word can be stretched. The stretch source is the external wait line, a down-counter preloaded per access, or a logical combination of the two.

Top module: `frame_bus_master`

## Requirements
- R1: Each frame begins at buffer word 0 and moves TRIGGER+1 words in ascending order. `position` shows the index of the word on the bus and is 0 on the cycle the strobe rises.
- R2: A buffer access hits the trigger word only when byte-address bits 9..2 equal TRIGGER. Bits 17..10 and 1..0 have no effect on whether it hits.
- R3: In send mode (operation bit 8 = 0), a CPU write to the trigger word starts a frame. During that frame `busWrite` is 1, and while `position` is i, `busWdata` carries buffer word i.
- R4: Writing the operation register (regSel = 1, bits 7..0 = TRIGGER, bit 8 = 1 for fetch) with bit 8 set starts a fetch. Each bus word read at `busRdata` is stored at the current buffer index. A CPU read returns buffer data on `bufRdata` one cycle after `bufRe`.
- R5: In fetch mode, a CPU read of the trigger word starts another fetch when auto-restart (control bit 2) is 1. It has no effect when auto-restart is 0.
- R6: `busy` is 1 from the cycle after a start request until the last word completes. `done` becomes 1 as the frame completes and clears on the next CPU buffer read or write.
- R7: Control bits 11..8 preload a wait counter at the start of each bus word. The counter decrements each bus tick until it reaches 0. Control bits 5..4 select the stretch source: 00 external wait only, 01 counter nonzero only, 10 either, 11 both. The word is held while the selected source is 1.
- R8: When increment (control bit 0) is 1, `busAddr` advances by 1 after every word. When reload (control bit 1) is 1, `busAddr` returns to the start address (regSel = 0) after each frame.
- R9: When the pulse enable (control bit 3) is 1, `lastWord` is 1 while the final word of the frame is on the bus. When the pulse enable is 0, `lastWord` stays 0.
- R10: `busPhase` alternates every system cycle, starting at 0 after reset. Bus-side state (`position`, `busStrobe`) changes only on edges where `busPhase` was 1.
- R11: Register writes (regSel 0 start address, 1 operation, 2 control) made while `busy` is 1 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 start address, 1 operation, 2 control |
| regWdata | input | 32 | Register write data |
| bufWe | input | 1 | CPU buffer write |
| bufRe | input | 1 | CPU buffer read |
| bufAddr | input | 18 | CPU byte address into the buffer |
| bufWdata | input | DATA_W | CPU buffer write data |
| bufRdata | output | DATA_W | CPU buffer read data, one cycle after bufRe |
| busy | output | 1 | Frame requested or in flight |
| done | output | 1 | Frame completed, not yet acknowledged |
| position | output | 8 | Index of the word on the bus |
| lastWord | output | 1 | Final word of the frame on the bus |
| busPhase | output | 1 | Bus clock enable, half system rate |
| busAddr | output | BUS_ADDR_W | External bus address |
| busWdata | output | DATA_W | External bus write data |
| busRdata | input | DATA_W | External bus read data |
| busStrobe | output | 1 | Bus access in progress |
| busWrite | output | 1 | 1 for a write access, 0 for a read |
| busWaitIn | input | 1 | External wait, stretches the access while 1 |

## Verification
If the word index or the wait counter holds a wrong value, the strobe length and `busWdata` differ from the reference within one bus tick, which is two system cycles. A wrong address step or restore shows on `busAddr` as soon as the affected word completes. A fetched word stored at the wrong buffer index stays hidden until the CPU reads it back one cycle later. For that reason, fetched frames are always read back and compared with bus data derived from the address. Start-decode errors show on `busy` in the cycle after the buffer access.

// File: rtl/fbm_pkg.sv
package fbm_pkg;
  localparam int POS_W  = 8;
  localparam int WAIT_W = 4;

  localparam logic [1:0] SEL_START = 2'd0;
  localparam logic [1:0] SEL_OP    = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  typedef enum logic [1:0] {
    RDY_EXT = 2'b00,
    RDY_CNT = 2'b01,
    RDY_OR  = 2'b10,
    RDY_AND = 2'b11
  } rdy_mode_e;

  typedef struct packed {
    logic [POS_W-1:0]  trigger;
    logic              readMode;
    logic              incr;
    logic              reload;
    logic              autoRestart;
    logic              pulseEn;
    rdy_mode_e         readyMode;
    logic [WAIT_W-1:0] waitCount;
  } cfg_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic wordDone;
    logic frameEnd;
  } strobe_t;
endpackage

// File: rtl/fbm_ctrl.sv
module fbm_ctrl
  import fbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  cfg_t             cfg,
  input  logic             cntNz,
  input  logic             busWaitIn,
  input  logic             bufWe,
  input  logic             bufRe,
  input  logic [POS_W-1:0] bufIdx,
  input  logic             opStart,
  output strobe_t          stb,
  output logic [POS_W-1:0] pos,
  output logic             busy,
  output logic             done,
  output logic             active,
  output logic             tick,
  output logic             lastWord
);
  logic pending;
  logic trigHit;
  logic lastPos;
  logic waitNow;
  logic startReq;

  assign busy    = pending | active;
  assign trigHit = (bufIdx == cfg.trigger);
  assign lastPos = (pos == cfg.trigger);

  // stretch source selection
  always_comb begin
    case (cfg.readyMode)
      RDY_EXT: waitNow = busWaitIn;
      RDY_CNT: waitNow = cntNz;
      RDY_OR:  waitNow = busWaitIn | cntNz;
      default: waitNow = busWaitIn & cntNz;
    endcase
  end

  assign startReq = !busy &&
                    ((bufWe && trigHit && !cfg.readMode) ||
                     opStart ||
                     (bufRe && trigHit && cfg.readMode && cfg.autoRestart));

  always_comb begin
    stb = '0;
    if (tick) begin
      if (!active && pending) begin
        stb.loadCnt = 1'b1;
      end else if (active) begin
        if (waitNow) begin
          stb.decCnt = 1'b1;
        end else begin
          stb.wordDone = 1'b1;
          stb.frameEnd = lastPos;
          stb.loadCnt  = !lastPos;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= 1'b0;
      pending <= 1'b0;
      active  <= 1'b0;
      pos     <= '0;
      done    <= 1'b0;
    end else begin
      tick <= !tick;
      if (startReq) pending <= 1'b1;
      if (tick && !active && pending) begin
        active  <= 1'b1;
        pending <= 1'b0;
        pos     <= '0;
      end else if (stb.wordDone) begin
        if (lastPos) active <= 1'b0;
        else         pos    <= pos + 1'b1;
      end
      if (stb.frameEnd)        done <= 1'b1;
      else if (bufWe || bufRe) done <= 1'b0;
    end
  end

  assign lastWord = cfg.pulseEn && active && lastPos;
endmodule

// File: rtl/fbm_datapath.sv
module fbm_datapath
  import fbm_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BUS_ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  regWe,
  input  logic [1:0]            regSel,
  input  logic [31:0]           regWdata,
  input  logic                  busy,
  input  logic                  bufWe,
  input  logic                  bufRe,
  input  logic [POS_W-1:0]      bufIdx,
  input  logic [DATA_W-1:0]     bufWdata,
  output logic [DATA_W-1:0]     bufRdata,
  input  logic [POS_W-1:0]      pos,
  input  strobe_t               stb,
  input  logic [DATA_W-1:0]     busRdata,
  output cfg_t                  cfg,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busWdata,
  output logic                  cntNz
);
  localparam int DEPTH = 1 << POS_W;

  logic [DATA_W-1:0]     mem [DEPTH];
  logic [BUS_ADDR_W-1:0] startAddr;
  logic [WAIT_W-1:0]     cnt;
  logic                  regOk;
  logic                  unusedRegBits;

  assign regOk         = regWe && !busy;
  assign unusedRegBits = ^regWdata;
  assign cntNz         = (cnt != '0);
  assign busWdata      = mem[pos];

  // buffer: bus-side write takes the later slot and wins a collision
  always_ff @(posedge clk) begin
    if (bufWe) mem[bufIdx] <= bufWdata;
    if (stb.wordDone && cfg.readMode) mem[pos] <= busRdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        bufRdata <= '0;
    else if (bufRe) bufRdata <= mem[bufIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (regOk && regSel == SEL_OP) begin
      cfg.trigger  <= regWdata[POS_W-1:0];
      cfg.readMode <= regWdata[8];
    end else if (regOk && regSel == SEL_CTRL) begin
      cfg.incr        <= regWdata[0];
      cfg.reload      <= regWdata[1];
      cfg.autoRestart <= regWdata[2];
      cfg.pulseEn     <= regWdata[3];
      cfg.readyMode   <= rdy_mode_e'(regWdata[5:4]);
      cfg.waitCount   <= regWdata[8 +: WAIT_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      startAddr <= '0;
      busAddr   <= '0;
    end else if (regOk && regSel == SEL_START) begin
      startAddr <= regWdata[BUS_ADDR_W-1:0];
      busAddr   <= regWdata[BUS_ADDR_W-1:0];
    end else if (stb.wordDone) begin
      if (stb.frameEnd && cfg.reload) busAddr <= startAddr;
      else if (cfg.incr)              busAddr <= busAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (stb.loadCnt)        cnt <= cfg.waitCount;
    else if (stb.decCnt && cntNz) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/frame_bus_master.sv
module frame_bus_master
  import fbm_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BUS_ADDR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  regWe,
  input  logic [1:0]            regSel,
  input  logic [31:0]           regWdata,
  input  logic                  bufWe,
  input  logic                  bufRe,
  input  logic [17:0]           bufAddr,
  input  logic [DATA_W-1:0]     bufWdata,
  output logic [DATA_W-1:0]     bufRdata,
  output logic                  busy,
  output logic                  done,
  output logic [POS_W-1:0]      position,
  output logic                  lastWord,
  output logic                  busPhase,
  output logic [BUS_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busWdata,
  input  logic [DATA_W-1:0]     busRdata,
  output logic                  busStrobe,
  output logic                  busWrite,
  input  logic                  busWaitIn
);
  cfg_t             cfg;
  strobe_t          stb;
  logic [POS_W-1:0] bufIdx;
  logic             cntNz;
  logic             active;
  logic             opStart;
  logic             unusedAddrBits;

  assign bufIdx         = bufAddr[POS_W+1:2];
  assign unusedAddrBits = ^{bufAddr[17:POS_W+2], bufAddr[1:0]};
  assign opStart        = regWe && (regSel == SEL_OP) && regWdata[8];

  fbm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfg(cfg), .cntNz(cntNz), .busWaitIn(busWaitIn),
    .bufWe(bufWe), .bufRe(bufRe), .bufIdx(bufIdx), .opStart(opStart),
    .stb(stb), .pos(position), .busy(busy), .done(done), .active(active),
    .tick(busPhase), .lastWord(lastWord)
  );

  fbm_datapath #(.DATA_W(DATA_W), .BUS_ADDR_W(BUS_ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busy(busy), .bufWe(bufWe), .bufRe(bufRe), .bufIdx(bufIdx),
    .bufWdata(bufWdata), .bufRdata(bufRdata), .pos(position), .stb(stb),
    .busRdata(busRdata), .cfg(cfg), .busAddr(busAddr), .busWdata(busWdata),
    .cntNz(cntNz)
  );

  assign busStrobe = active;
  assign busWrite  = active && !cfg.readMode;
endmodule

// File: rtl/fbm_checker.sv
module fbm_checker (
  input logic       clk,
  input logic       rst,
  input logic       busPhase,
  input logic       busStrobe,
  input logic       busy,
  input logic       done,
  input logic       lastWord,
  input logic [7:0] position,
  input logic       bufWe,
  input logic       bufRe
);
  // R10
  phase_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(busPhase) |-> ($stable(position) && $stable(busStrobe)));

  // R6
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busStrobe |-> busy);

  // R9
  last_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    lastWord |-> busStrobe);

  // R1
  frame_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busStrobe) |-> (position == 8'd0));

  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $fell(busy));

  // R6
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(bufWe || bufRe));
endmodule

bind frame_bus_master fbm_checker u_chk (
  .clk(clk), .rst(rst), .busPhase(busPhase), .busStrobe(busStrobe),
  .busy(busy), .done(done), .lastWord(lastWord), .position(position),
  .bufWe(bufWe), .bufRe(bufRe)
);

// File: tb/frame_bus_master_test.sv
`timescale 1ns/1ps
module frame_bus_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        bufWe = 1'b0;
  logic        bufRe = 1'b0;
  logic [17:0] bufAddr = '0;
  logic [31:0] bufWdata = '0;
  logic [31:0] bufRdata;
  logic        busy, done, lastWord, busPhase, busStrobe, busWrite;
  logic [7:0]  position;
  logic [15:0] busAddr;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic        busWaitIn = 1'b0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int strobeCnt, lastCnt;

  always #2.5 clk = ~clk;

  frame_bus_master uut (
    .clk(clk), .rst(rst), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .bufWe(bufWe), .bufRe(bufRe), .bufAddr(bufAddr), .bufWdata(bufWdata),
    .bufRdata(bufRdata), .busy(busy), .done(done), .position(position),
    .lastWord(lastWord), .busPhase(busPhase), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busStrobe(busStrobe),
    .busWrite(busWrite), .busWaitIn(busWaitIn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // external bus slave: data derived from the address
  always @(negedge clk) busRdata <= 32'hC0DE0000 | {16'h0, busAddr};

  // behavioural reference model
  logic [31:0] mMem [256];
  logic [31:0] mRd;
  logic [15:0] mAddr, mStart;
  logic [7:0]  mTrig;
  int          mPos, mCnt, mWait;
  logic [1:0]  mMode;
  logic mPhase, mPend, mAct, mDone, mRead, mIncr, mReload, mAuto, mPulse;
  logic mBusy, mHit, mStartNow, mWaitNow;

  always @(posedge clk) begin
    if (rst) begin
      mRd = '0; mAddr = '0; mStart = '0; mTrig = '0; mPos = 0; mCnt = 0; mWait = 0;
      mMode = '0; mPhase = 0; mPend = 0; mAct = 0; mDone = 0; mRead = 0;
      mIncr = 0; mReload = 0; mAuto = 0; mPulse = 0;
    end else begin
      mBusy = mPend || mAct;
      mHit  = (bufAddr[9:2] == mTrig);
      mStartNow = !mBusy && ((bufWe && mHit && !mRead) ||
                             (regWe && regSel == 2'd1 && regWdata[8]) ||
                             (bufRe && mHit && mRead && mAuto));
      if (bufRe) mRd = mMem[bufAddr[9:2]];
      if (bufWe) mMem[bufAddr[9:2]] = bufWdata;
      if (bufWe || bufRe) mDone = 0;
      if (regWe && !mBusy) begin
        case (regSel)
          2'd0: begin mStart = regWdata[15:0]; mAddr = regWdata[15:0]; end
          2'd1: begin mTrig = regWdata[7:0]; mRead = regWdata[8]; end
          2'd2: begin
            mIncr = regWdata[0]; mReload = regWdata[1]; mAuto = regWdata[2];
            mPulse = regWdata[3]; mMode = regWdata[5:4]; mWait = int'(regWdata[11:8]);
          end
          default: ;
        endcase
      end
      if (mPhase) begin
        if (!mAct && mPend) begin
          mAct = 1; mPend = 0; mPos = 0; mCnt = mWait;
        end else if (mAct) begin
          case (mMode)
            2'b00: mWaitNow = busWaitIn;
            2'b01: mWaitNow = (mCnt != 0);
            2'b10: mWaitNow = busWaitIn || (mCnt != 0);
            default: mWaitNow = busWaitIn && (mCnt != 0);
          endcase
          if (mWaitNow) begin
            if (mCnt != 0) mCnt = mCnt - 1;
          end else begin
            if (mRead) mMem[mPos] = busRdata;
            if (mPos == int'(mTrig)) begin
              mAct = 0; mDone = 1;
              if (mReload) mAddr = mStart;
              else if (mIncr) mAddr = mAddr + 16'd1;
            end else begin
              mPos = mPos + 1; mCnt = mWait;
              if (mIncr) mAddr = mAddr + 16'd1;
            end
          end
        end
      end
      if (mStartNow) mPend = 1;
      mPhase = !mPhase;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R10 busPhase", {31'b0, busPhase}, {31'b0, mPhase});
      check("R1 position", {24'b0, position}, 32'(mPos));
      check("R3 busStrobe", {31'b0, busStrobe}, {31'b0, mAct});
      check("R3 busWrite", {31'b0, busWrite}, {31'b0, mAct && !mRead});
      check("R6 busy", {31'b0, busy}, {31'b0, mPend || mAct});
      check("R6 done", {31'b0, done}, {31'b0, mDone});
      check("R8 busAddr", {16'b0, busAddr}, {16'b0, mAddr});
      check("R9 lastWord", {31'b0, lastWord}, {31'b0, mPulse && mAct && (mPos == int'(mTrig))});
      check("R4 bufRdata", bufRdata, mRd);
      if (busStrobe && busWrite) check("R3 busWdata", busWdata, mMem[mPos]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); regWe = 1'b1; regSel = sel; regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic buf_write(input logic [17:0] a, input logic [31:0] d);
    @(negedge clk); bufWe = 1'b1; bufAddr = a; bufWdata = d;
    @(negedge clk); bufWe = 1'b0;
  endtask

  task automatic buf_read(input logic [17:0] a, output logic [31:0] d);
    @(negedge clk); bufRe = 1'b1; bufAddr = a;
    @(negedge clk); bufRe = 1'b0; d = bufRdata;
  endtask

  task automatic wait_idle();
    strobeCnt = 0; lastCnt = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!busy) return;
      @(negedge clk);
      if (busStrobe) strobeCnt++;
      if (lastWord) lastCnt++;
    end
    check("R6 frame finishes", {31'b0, busy}, 32'd0);
  endtask

  function automatic logic [31:0] ctrlWord(input logic inc, input logic rel, input logic aut,
                                           input logic pul, input logic [1:0] md, input logic [3:0] w);
    return {20'b0, w, 2'b0, md, pul, aut, rel, inc};
  endfunction

  task automatic strobe_len(input logic [1:0] md, input logic [3:0] w, input logic ext, input int expLen);
    reg_write(2'd2, ctrlWord(1'b0, 1'b0, 1'b0, 1'b0, md, w));
    busWaitIn = ext;
    buf_write(18'h00000, 32'hBEEF0000 | {28'b0, w});
    wait_idle();
    check("R7 strobe length", 32'(strobeCnt), 32'(expLen));
    busWaitIn = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset busy", {31'b0, busy}, 32'd0);
    check("R6 reset done", {31'b0, done}, 32'd0);
    check("R3 reset strobe", {31'b0, busStrobe}, 32'd0);
    check("R1 reset position", {24'b0, position}, 32'd0);

    // send mode frame of 8 words
    for (int i = 0; i < 8; i++) buf_write(18'(i * 4), 32'h1000 + 32'(i));
    reg_write(2'd2, ctrlWord(1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 4'd1));
    reg_write(2'd0, 32'h0100);
    reg_write(2'd1, 32'h0007);
    buf_write(18'h00018, 32'h1006);
    @(negedge clk);
    check("R2 non-trigger word no start", {31'b0, busy}, 32'd0);
    buf_write(18'h3FC1F, 32'h1007);
    check("R2 trigger hit with high bits set", {31'b0, busy}, 32'd1);
    reg_write(2'd0, 32'h0200);
    wait_idle();
    check("R11 start address kept", {16'b0, busAddr}, 32'h0100);
    check("R8 reload after frame", {16'b0, busAddr}, 32'h0100);
    check("R9 no pulse when disabled", 32'(lastCnt), 32'd0);
    check("R6 done after frame", {31'b0, done}, 32'd1);
    buf_read(18'h00000, rd);
    check("R6 done cleared by access", {31'b0, done}, 32'd0);

    // fetch mode frame of 4 words
    reg_write(2'd2, ctrlWord(1'b1, 1'b0, 1'b0, 1'b1, 2'b00, 4'd0));
    reg_write(2'd0, 32'h0040);
    reg_write(2'd1, 32'h0103);
    check("R4 fetch starts on mode write", {31'b0, busy}, 32'd1);
    wait_idle();
    check("R8 increment without reload", {16'b0, busAddr}, 32'h0044);
    check("R9 pulse on last word", 32'(lastCnt), 32'd2);
    for (int i = 0; i < 4; i++) begin
      buf_read(18'(i * 4), rd);
      check("R4 fetched word", rd, 32'hC0DE0040 + 32'(i));
    end
    @(negedge clk);
    check("R5 no restart when disabled", {31'b0, busy}, 32'd0);

    reg_write(2'd2, ctrlWord(1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 4'd0));
    buf_read(18'h0000C, rd);
    check("R5 restart on trigger read", {31'b0, busy}, 32'd1);
    wait_idle();
    check("R8 address continues", {16'b0, busAddr}, 32'h0048);
    buf_read(18'h00000, rd);
    check("R4 refetched word", rd, 32'hC0DE0044);

    // single-word frames for stretch modes
    reg_write(2'd1, 32'h0000);
    strobe_len(2'b01, 4'd3, 1'b0, 8);
    strobe_len(2'b00, 4'd5, 1'b0, 2);
    strobe_len(2'b10, 4'd2, 1'b0, 6);
    strobe_len(2'b11, 4'd2, 1'b1, 6);
    strobe_len(2'b11, 4'd5, 1'b0, 2);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule